// File: doc/BRIEF.md
# Line-Based Instruction Fetch Unit

This unit feeds the decode side of a processor with 12-bit instruction words. Instead of handing over one word at a time, it delivers a whole four-word cache line per bundle, together with the exact program counter that decode should start from and a small generation tag. Decode uses the tag to tell which bundles are still valid after it has steered fetch somewhere else. Lines come from a small two-way set-associative store inside the unit. On a miss the unit asks an external memory for one line and accepts the returning line on a response port.

The 15-bit program counter is split into a 3-bit field number and a 12-bit offset. Sequential fetch never changes the field number. After each bundle it moves the offset to the start of the next line and wraps it within the field. A redirect from decode replaces the counter and the generation tag in the same cycle it arrives. The unit allows only one line request at a time. A line that arrives in some cycle is written into the store and can be handed out in that same cycle.

Top module: `ifu_line_fetch`

## Requirements
- R1: In the first cycle after reset, `bun_valid` is 0, `cmd_valid` is 1 and `cmd_line_addr` equals the reset counter shifted right by 2. The first bundle carries generation 0.
- R2: `cmd_valid` is 1 exactly when no line request is open and the line of the current counter is neither stored nor arriving in that cycle. `cmd_line_addr` is the current counter shifted right by 2 (4 words per line).
- R3: Once a request is accepted (`cmd_valid` and `cmd_ready` both high), `cmd_valid` stays 0 until a bundle is accepted or a redirect arrives.
- R4: A response whose `rsp_line_addr` equals the current line makes `bun_valid` 1 in that same cycle, with `bun_data` equal to `rsp_data`.
- R5: A bundle carries the full line (word 0 in bits 11:0, word 3 in bits 47:36), the current counter unchanged in `bun_pc`, and the current generation in `bun_gen`.
- R6: After a bundle is accepted, the counter becomes {same 3 field bits, (offset with low 2 bits cleared + 4) mod 4096}.
- R7: In a cycle with `redir_valid` high, the lookup, `bun_pc`, `bun_gen` and `cmd_line_addr` all use `redir_pc` and `redir_gen`, and any open request is dropped, so `cmd_valid` may rise in that cycle.
- R8: A response that arrives after a redirect for a line no longer wanted does not produce a bundle, but it is still stored. A later redirect to that line then hits without a request.
- R9: Each set holds two lines and replaces the one used least recently. Both filling a line and handing it out count as a use.
- R10: While `bun_valid` is 1 and `bun_ready` is 0, the counter and the bundle do not change.
- R11: The generation tag keeps the value of the last redirect (0 after reset) until the next redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redir_valid | input | 1 | Redirect strobe |
| redir_pc | input | 15 | New counter: field in 14:12, offset in 11:0 |
| redir_gen | input | 4 | New generation tag |
| cmd_valid | output | 1 | Line request valid |
| cmd_ready | input | 1 | Memory accepts request |
| cmd_line_addr | output | 13 | Requested line (counter >> 2) |
| rsp_valid | input | 1 | Returning line valid |
| rsp_line_addr | input | 13 | Line address of the returning line |
| rsp_data | input | 48 | Returning line, word 0 in the low bits |
| bun_valid | output | 1 | Bundle valid |
| bun_ready | input | 1 | Decode accepts bundle |
| bun_pc | output | 15 | Counter that the bundle was fetched for |
| bun_gen | output | 4 | Generation tag of the bundle |
| bun_data | output | 48 | Line contents |

## Verification
The bench goes after the counter step at the top of a field. A step that let the carry reach the field bits would request a line in the wrong field after offset 0xFFC. It drives a redirect while a request is open; a design that kept the open flag would never request the new line and would hang. It returns a late response for an abandoned line. A design that emitted that line would hand decode a wrong bundle, and one that dropped it would ask for the line again later. It also fills three lines into one set after touching the oldest, so a replacement that evicts by fill order instead of by use shows up as a miss on the touched line.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  // Default geometry of the fetch unit
  localparam int IFU_FIELD_W    = 3;
  localparam int IFU_OFF_W      = 12;
  localparam int IFU_WORD_W     = 12;
  localparam int IFU_LINE_WORDS = 4;
  localparam int IFU_SETS       = 8;
  localparam int IFU_GEN_W      = 4;

  // Way index type for the two-way line store
  typedef logic ifu_way_t;
endpackage

// File: rtl/ifu_pc_seq.sv
module ifu_pc_seq #(
  parameter int FIELD_W    = 3,
  parameter int OFF_W      = 12,
  parameter int LINE_WORDS = 4,
  parameter int GEN_W      = 4,
  parameter logic [FIELD_W+OFF_W-1:0] RESET_PC = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     redir_valid,
  input  logic [FIELD_W+OFF_W-1:0] redir_pc,
  input  logic [GEN_W-1:0]         redir_gen,
  input  logic                     emit,
  input  logic                     req_fire,
  output logic [FIELD_W+OFF_W-1:0] cur_pc,
  output logic [GEN_W-1:0]         cur_gen,
  output logic                     fill_open
);
  localparam int PC_W = FIELD_W + OFF_W;
  localparam logic [OFF_W-1:0] OFF_MASK = OFF_W'(LINE_WORDS - 1);
  localparam logic [OFF_W-1:0] OFF_STEP = OFF_W'(LINE_WORDS);

  logic [PC_W-1:0]  pc_q, pc_d;
  logic [GEN_W-1:0] gen_q;
  logic             open_q, open_d;
  logic             pc_en;
  logic [OFF_W-1:0] off_next;

  // A redirect takes effect in the cycle it arrives
  always_comb begin
    cur_pc    = redir_valid ? redir_pc  : pc_q;
    cur_gen   = redir_valid ? redir_gen : gen_q;
    fill_open = redir_valid ? 1'b0      : open_q;
  end

  always_comb begin
    off_next = (cur_pc[OFF_W-1:0] & ~OFF_MASK) + OFF_STEP;
    pc_d     = emit ? {cur_pc[PC_W-1:OFF_W], off_next} : cur_pc;
    pc_en    = redir_valid | emit;
    if (req_fire)  open_d = 1'b1;
    else if (emit) open_d = 1'b0;
    else           open_d = fill_open;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= RESET_PC;
      gen_q  <= '0;
      open_q <= 1'b0;
    end else begin
      if (pc_en)       pc_q  <= pc_d;
      if (redir_valid) gen_q <= redir_gen;
      open_q <= open_d;
    end
  end
endmodule

// File: rtl/ifu_line_cache.sv
module ifu_line_cache
  import ifu_pkg::*;
#(
  parameter int LINE_W = 13,
  parameter int DATA_W = 48,
  parameter int SETS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] look_line,
  input  logic              touch,
  input  logic              fill_valid,
  input  logic [LINE_W-1:0] fill_line,
  input  logic [DATA_W-1:0] fill_data,
  output logic              hit,
  output logic [DATA_W-1:0] hit_data
);
  localparam int WAYS  = 2;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = LINE_W - IDX_W;

  logic [WAYS-1:0]   vld_q [SETS];
  logic [WAYS-1:0]   vld_d [SETS];
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [DATA_W-1:0] dat_q [SETS][WAYS];
  logic [SETS-1:0]   mru_q, mru_d;

  logic [IDX_W-1:0] lidx, fidx;
  logic [TAG_W-1:0] ltag, ftag;
  logic [WAYS-1:0]  way_hit, fill_match;
  logic             bypass;
  ifu_way_t         hit_way, fill_way, use_way;

  assign lidx = look_line[IDX_W-1:0];
  assign ltag = look_line[LINE_W-1:IDX_W];
  assign fidx = fill_line[IDX_W-1:0];
  assign ftag = fill_line[LINE_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_hit[w]    = vld_q[lidx][w] && (tag_q[lidx][w] == ltag);
    assign fill_match[w] = vld_q[fidx][w] && (tag_q[fidx][w] == ftag);
  end

  // Lookup, with the arriving line visible in the same cycle
  always_comb begin
    bypass  = fill_valid && (fill_line == look_line);
    hit     = bypass || (|way_hit);
    hit_way = way_hit[1];
    if (|fill_match)          fill_way = fill_match[1];
    else if (!vld_q[fidx][0]) fill_way = 1'b0;
    else if (!vld_q[fidx][1]) fill_way = 1'b1;
    else                      fill_way = ~mru_q[fidx];
    use_way  = bypass ? fill_way : hit_way;
    hit_data = bypass ? fill_data : dat_q[lidx][hit_way];
  end

  always_comb begin
    vld_d = vld_q;
    mru_d = mru_q;
    if (fill_valid) begin
      vld_d[fidx][fill_way] = 1'b1;
      mru_d[fidx]           = fill_way;
    end
    if (touch) mru_d[lidx] = use_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      mru_q <= '0;
    end else if (fill_valid || touch) begin
      vld_q <= vld_d;
      mru_q <= mru_d;
    end
  end

  // Tag and data arrays carry no reset
  always_ff @(posedge clk) begin
    if (fill_valid) begin
      tag_q[fidx][fill_way] <= ftag;
      dat_q[fidx][fill_way] <= fill_data;
    end
  end
endmodule

// File: rtl/ifu_line_fetch.sv
module ifu_line_fetch
  import ifu_pkg::*;
#(
  parameter int FIELD_W    = IFU_FIELD_W,
  parameter int OFF_W      = IFU_OFF_W,
  parameter int WORD_W     = IFU_WORD_W,
  parameter int LINE_WORDS = IFU_LINE_WORDS,
  parameter int SETS       = IFU_SETS,
  parameter int GEN_W      = IFU_GEN_W,
  parameter logic [FIELD_W+OFF_W-1:0] RESET_PC = '0
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   redir_valid,
  input  logic [FIELD_W+OFF_W-1:0]               redir_pc,
  input  logic [GEN_W-1:0]                       redir_gen,
  output logic                                   cmd_valid,
  input  logic                                   cmd_ready,
  output logic [FIELD_W+OFF_W-$clog2(LINE_WORDS)-1:0] cmd_line_addr,
  input  logic                                   rsp_valid,
  input  logic [FIELD_W+OFF_W-$clog2(LINE_WORDS)-1:0] rsp_line_addr,
  input  logic [WORD_W*LINE_WORDS-1:0]           rsp_data,
  output logic                                   bun_valid,
  input  logic                                   bun_ready,
  output logic [FIELD_W+OFF_W-1:0]               bun_pc,
  output logic [GEN_W-1:0]                       bun_gen,
  output logic [WORD_W*LINE_WORDS-1:0]           bun_data
);
  localparam int PC_W    = FIELD_W + OFF_W;
  localparam int LW_LOG2 = $clog2(LINE_WORDS);
  localparam int LINE_W  = PC_W - LW_LOG2;
  localparam int DATA_W  = WORD_W * LINE_WORDS;

  logic [PC_W-1:0]   cur_pc;
  logic [GEN_W-1:0]  cur_gen;
  logic              fill_open;
  logic [LINE_W-1:0] cur_line;
  logic              line_hit;
  logic [DATA_W-1:0] line_data;
  logic              emit, req_fire;

  assign cur_line = cur_pc[PC_W-1:LW_LOG2];
  assign emit     = line_hit && bun_ready;
  assign req_fire = cmd_valid && cmd_ready;

  ifu_pc_seq #(
    .FIELD_W(FIELD_W), .OFF_W(OFF_W), .LINE_WORDS(LINE_WORDS),
    .GEN_W(GEN_W), .RESET_PC(RESET_PC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_gen(redir_gen),
    .emit(emit), .req_fire(req_fire),
    .cur_pc(cur_pc), .cur_gen(cur_gen), .fill_open(fill_open)
  );

  ifu_line_cache #(.LINE_W(LINE_W), .DATA_W(DATA_W), .SETS(SETS)) u_cache (
    .clk(clk), .rst_n(rst_n),
    .look_line(cur_line), .touch(emit),
    .fill_valid(rsp_valid), .fill_line(rsp_line_addr), .fill_data(rsp_data),
    .hit(line_hit), .hit_data(line_data)
  );

  always_comb begin
    cmd_valid     = !fill_open && !line_hit;
    cmd_line_addr = cur_line;
    bun_valid     = line_hit;
    bun_pc        = cur_pc;
    bun_gen       = cur_gen;
    bun_data      = line_data;
  end
endmodule

// File: rtl/ifu_line_fetch_chk.sv
module ifu_line_fetch_chk #(
  parameter int PC_W    = 15,
  parameter int OFF_W   = 12,
  parameter int GEN_W   = 4,
  parameter int LW_LOG2 = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    redir_valid,
  input logic [PC_W-1:0]         redir_pc,
  input logic [GEN_W-1:0]        redir_gen,
  input logic                    cmd_valid,
  input logic                    cmd_ready,
  input logic [PC_W-LW_LOG2-1:0] cmd_line_addr,
  input logic                    bun_valid,
  input logic                    bun_ready,
  input logic [PC_W-1:0]         bun_pc,
  input logic [GEN_W-1:0]        bun_gen
);
  localparam logic [OFF_W-1:0] LOW_MASK = OFF_W'((1 << LW_LOG2) - 1);
  localparam logic [OFF_W-1:0] STEP     = OFF_W'(1 << LW_LOG2);

  logic [PC_W-1:0]         prev_pc_q;
  logic [OFF_W-1:0]        exp_off;
  logic [PC_W-1:0]         exp_pc;
  logic [PC_W-LW_LOG2-1:0] exp_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_pc_q <= '0;
    else        prev_pc_q <= bun_pc;
  end

  always_comb begin
    exp_off  = (prev_pc_q[OFF_W-1:0] & ~LOW_MASK) + STEP;
    exp_pc   = {prev_pc_q[PC_W-1:OFF_W], exp_off};
    exp_line = exp_pc[PC_W-1:LW_LOG2];
  end

  AST_NO_REQ_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && bun_valid)); // R2

  AST_ONE_OPEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!cmd_valid || redir_valid)); // R3

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bun_valid && bun_ready) |=> (redir_valid || cmd_line_addr == exp_line)); // R6

  AST_REDIR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (cmd_line_addr == redir_pc[PC_W-1:LW_LOG2] && bun_gen == redir_gen)); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bun_valid && !bun_ready) |=> (redir_valid || bun_pc == $past(bun_pc))); // R10

  AST_GEN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (redir_valid || bun_gen == $past(redir_gen))); // R11
endmodule

bind ifu_line_fetch ifu_line_fetch_chk #(
  .PC_W(PC_W), .OFF_W(OFF_W), .GEN_W(GEN_W), .LW_LOG2(LW_LOG2)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_gen(redir_gen),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_line_addr(cmd_line_addr),
  .bun_valid(bun_valid), .bun_ready(bun_ready), .bun_pc(bun_pc), .bun_gen(bun_gen)
);

// File: tb/sim_ifu_line_fetch.sv
module sim_ifu_line_fetch;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redir_valid = 1'b0;
  logic [14:0] redir_pc = '0;
  logic [3:0]  redir_gen = '0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [12:0] cmd_line_addr;
  logic        rsp_valid = 1'b0;
  logic [12:0] rsp_line_addr = '0;
  logic [47:0] rsp_data = '0;
  logic        bun_valid;
  logic        bun_ready = 1'b0;
  logic [14:0] bun_pc;
  logic [3:0]  bun_gen;
  logic [47:0] bun_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifu_line_fetch u0 (
    .clk(clk), .rst_n(rst_n),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_gen(redir_gen),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_line_addr(cmd_line_addr),
    .rsp_valid(rsp_valid), .rsp_line_addr(rsp_line_addr), .rsp_data(rsp_data),
    .bun_valid(bun_valid), .bun_ready(bun_ready),
    .bun_pc(bun_pc), .bun_gen(bun_gen), .bun_data(bun_data)
  );

  typedef struct packed {
    logic [14:0] pc;
    logic [3:0]  gen;
    logic [12:0] next_line;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{pc: 15'h0005, gen: 4'd3,  next_line: 13'h0002},
    '{pc: 15'h7FFE, gen: 4'd9,  next_line: 13'h1C00},
    '{pc: 15'h1233, gen: 4'd15, next_line: 13'h048D},
    '{pc: 15'h3FFC, gen: 4'd0,  next_line: 13'h0C00},
    '{pc: 15'h2101, gen: 4'd7,  next_line: 13'h0841},
    '{pc: 15'h4002, gen: 4'd5,  next_line: 13'h1001}
  };

  function automatic logic [47:0] line_word(input logic [12:0] ln);
    return {ln[11:0], ~ln[11:0], ln[11:0] ^ 12'hA5A, ln[11:0] + 12'h123};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fill_line(input logic [14:0] pc, input logic [3:0] gen);
    redir_valid = 1'b1; redir_pc = pc; redir_gen = gen;
    cmd_ready = 1'b1; bun_ready = 1'b1;
    #1 check("R2 request", cmd_valid, 1);
    check("R2 line", cmd_line_addr, pc >> 2);
    step();
    redir_valid = 1'b0;
    rsp_valid = 1'b1; rsp_line_addr = pc >> 2; rsp_data = line_word(pc >> 2);
    #1 check("R4 fill hit", bun_valid, 1);
    step();
    rsp_valid = 1'b0; cmd_ready = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1 no bundle", bun_valid, 0);
    check("R1 request", cmd_valid, 1);
    check("R1 line", cmd_line_addr, 0);
    cmd_ready = 1'b1;
    step();
    cmd_ready = 1'b0;
    rsp_valid = 1'b1; rsp_line_addr = 13'h0; rsp_data = line_word(13'h0);
    #1 check("R1 first pc", bun_pc, 0);
    check("R11 reset gen", bun_gen, 0);
    step();
    rsp_valid = 1'b0;

    // Table of redirects: request, single open fill, same-cycle fill, step
    foreach (VECS[i]) begin
      redir_valid = 1'b1; redir_pc = VECS[i].pc; redir_gen = VECS[i].gen;
      cmd_ready = 1'b1; bun_ready = 1'b1;
      #1 check("R7 request on redirect", cmd_valid, 1);
      check("R2 line addr", cmd_line_addr, VECS[i].pc >> 2);
      check("R2 no bundle on miss", bun_valid, 0);
      step();
      redir_valid = 1'b0;
      #1 check("R3 one open fill", cmd_valid, 0);
      step();
      #1 check("R3 still waiting", cmd_valid, 0);
      rsp_valid = 1'b1; rsp_line_addr = VECS[i].pc >> 2; rsp_data = line_word(VECS[i].pc >> 2);
      #1 check("R4 same-cycle bundle", bun_valid, 1);
      check("R5 data", bun_data, line_word(VECS[i].pc >> 2));
      check("R5 pc", bun_pc, VECS[i].pc);
      check("R5 gen", bun_gen, VECS[i].gen);
      step();
      rsp_valid = 1'b0;
      #1 check("R6 next request", cmd_valid, 1);
      check("R6 next line", cmd_line_addr, VECS[i].next_line);
      cmd_ready = 1'b0;
    end

    // R8: late fill after redirect is stored but not emitted
    redir_valid = 1'b1; redir_pc = 15'h000C; redir_gen = 4'd2;
    cmd_ready = 1'b1; bun_ready = 1'b1;
    #1 check("R2 line 3", cmd_line_addr, 13'h3);
    step();
    redir_pc = 15'h0204; redir_gen = 4'd4;
    #1 check("R7 open fill dropped", cmd_valid, 1);
    check("R7 new line", cmd_line_addr, 13'h81);
    step();
    redir_valid = 1'b0;
    rsp_valid = 1'b1; rsp_line_addr = 13'h3; rsp_data = line_word(13'h3);
    #1 check("R8 stale not emitted", bun_valid, 0);
    step();
    rsp_line_addr = 13'h81; rsp_data = line_word(13'h81);
    #1 check("R11 gen after redirect", bun_gen, 4);
    check("R4 wanted line", bun_valid, 1);
    step();
    rsp_valid = 1'b0; cmd_ready = 1'b0; bun_ready = 1'b0;
    redir_valid = 1'b1; redir_pc = 15'h000E; redir_gen = 4'd6;
    #1 check("R8 stale line hits", bun_valid, 1);
    check("R8 stale data", bun_data, line_word(13'h3));
    check("R8 no request", cmd_valid, 0);
    step();
    redir_valid = 1'b0;
    #1 check("R10 hold valid", bun_valid, 1);
    check("R10 hold pc", bun_pc, 15'h000E);
    step();
    #1 check("R10 hold pc again", bun_pc, 15'h000E);
    check("R11 gen kept", bun_gen, 6);
    bun_ready = 1'b1;
    step();
    bun_ready = 1'b0;
    #1 check("R6 step after stall", cmd_line_addr, 13'h4);

    // R9: least recently used line is replaced
    fill_line(15'h0014, 4'd1);
    fill_line(15'h0034, 4'd1);
    redir_valid = 1'b1; redir_pc = 15'h0014; redir_gen = 4'd1; bun_ready = 1'b1;
    #1 check("R9 touch older line", bun_valid, 1);
    step();
    redir_valid = 1'b0;
    fill_line(15'h0054, 4'd1);
    redir_valid = 1'b1; redir_pc = 15'h0014; bun_ready = 1'b0;
    #1 check("R9 touched line kept", bun_valid, 1);
    step();
    redir_pc = 15'h0034;
    #1 check("R9 unused line evicted", bun_valid, 0);
    check("R9 refetch request", cmd_valid, 1);
    step();
    redir_valid = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule